// File: doc/BRIEF.md
# PN Code Phase Acquisition by Matched Filter

This block finds the code phase of a baseband chip stream that was spread by a 63-chip maximal-length PN code. Each received chip enters a delay line as wide as one code period. The whole line is correlated in parallel against one stored period of the local code. The resulting signed correlation is compared in magnitude with a programmable threshold. When the magnitude is larger than the threshold, the block emits a single-cycle sync pulse. The pulse marks the chip at which the received code lines up with the local code.

Every strobed chip gives a fresh decision, and the code has one correlation peak per period. On a clean stream the block therefore acquires within one code period once its window is full. A data bit of 1 inverts every chip, which turns the peak negative. The magnitude comparison treats both polarities the same way, and the sign of the reported correlation carries the data bit. After a detection the detector ignores the following 62 chips, so that the one peak in each period gives one pulse.

Top module: `pn_mf_acq`

## Requirements
- R1: While reset is asserted and in the cycle after it is released, `corr_out` is 0 and `sync_out` is 0.
- R2: The delay line and `corr_out` change only at a clock edge where `chip_vld` is 1. In cycles without a strobe, `corr_out` holds its value.
- R3: At a strobe edge, `corr_out` becomes the sum over the 63 most recent chips, including the one just strobed. The oldest chip is compared with code chip 0 and the newest with code chip 62. A tap adds +1 when the chip equals the code chip and −1 when it differs, so the mapping is 0→+1 and 1→−1. The value lies in −63..+63 and is always odd.
- R4: The stored code is a0..a62 with a0..a5 = 1 and a(n) = a(n−5) XOR a(n−6). A received run equal to that period, oldest chip first, gives +63.
- R5: `sync_out` is 1 in the cycle after a strobe edge only if |corr_out| is strictly greater than the `thr` value sampled at that edge, and the blanking and fill rules allow it. It is never high for two cycles from one strobe, and `corr_out` shows the detected value in the same cycle.
- R6: A window that is the exact inverse of the code gives −63, and that window is detected the same way as a +63 window.
- R7: No sync is issued until 63 chips have been strobed since reset. The 63rd strobe may itself produce a sync.
- R8: After a sync, the next 62 strobes cannot produce a sync. The 63rd strobe after it may.
- R9: With `thr` = 63, no sync is ever issued.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| chip_vld | input | 1 | Chip strobe; `chip_in` is taken at this edge |
| chip_in | input | 1 | Received hard-decision chip |
| thr | input | 6 | Detection threshold on the correlation magnitude |
| corr_out | output | 7 | Signed correlation of the current window |
| sync_out | output | 1 | One-cycle pulse marking code phase alignment |

## Verification
The assertions take for granted that `chip_vld` is held low while reset is asserted. They also assume that `thr` only matters at strobe edges, so a change between strobes is harmless. The bench keeps within these limits: it drives the strobe low during every reset and changes the threshold only at phase boundaries. Strobe spacing is irregular, from back-to-back strobes to gaps of several cycles, and the hold property is checked across those gaps.

// File: rtl/pnacq_pkg.sv
package pnacq_pkg;

  localparam int MAX_LEN = 1023;

  // One period of a maximal-length sequence; bit n is chip n.
  // a(n) = a(n-deg+tap) ^ a(n-deg), first deg chips all ones.
  function automatic logic [MAX_LEN-1:0] mseq_bits(input int deg, input int tap);
    logic [MAX_LEN-1:0] a;
    int len;
    a = '0;
    len = (1 << deg) - 1;
    for (int n = 0; n < MAX_LEN; n++) begin
      if (n < len) begin
        if (n < deg) a[n] = 1'b1;
        else         a[n] = a[n-deg+tap] ^ a[n-deg];
      end
    end
    return a;
  endfunction

  // agreement count to bipolar correlation
  function automatic int corr_from_agree(input int agree, input int len);
    return 2 * agree - len;
  endfunction

  function automatic int iabs(input int v);
    return (v < 0) ? -v : v;
  endfunction

endpackage

// File: rtl/pnacq_window.sv
module pnacq_window #(
  parameter int LEN = 63
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           shift,
  input  logic           din,
  output logic [LEN-1:0] win_q,
  output logic [LEN-1:0] win_nx
);

  // bit 0 newest, bit LEN-1 oldest
  assign win_nx = {win_q[LEN-2:0], din};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     win_q <= '0;
    else if (shift) win_q <= win_nx;
  end

  p_shift_in_r2: assert property (@(posedge clk) disable iff (!rst_n)
    shift |=> win_q[0] == $past(din));

  p_hold_idle_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !shift |=> $stable(win_q));

endmodule

// File: rtl/pnacq_corr.sv
module pnacq_corr #(
  parameter int LEN = 63,
  parameter int SW  = 7
) (
  input  logic                 [LEN-1:0] win,
  input  logic                 [LEN-1:0] coef,
  output logic signed          [SW-1:0]  sum
);

  logic [LEN-1:0] agree_bit;

  // tap j (j=0 newest) pairs with code chip LEN-1-j
  for (genvar j = 0; j < LEN; j++) begin : g_tap
    assign agree_bit[j] = ~(win[j] ^ coef[LEN-1-j]);
  end

  always_comb begin
    int agree;
    agree = 0;
    for (int j = 0; j < LEN; j++) begin
      agree = agree + int'(agree_bit[j]);
    end
    sum = SW'(pnacq_pkg::corr_from_agree(agree, LEN));
  end

endmodule

// File: rtl/pnacq_detect.sv
module pnacq_detect #(
  parameter int LEN = 63,
  parameter int SW  = 7,
  parameter int TW  = 6
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 strobe,
  input  logic signed [SW-1:0] sum_nx,
  input  logic        [TW-1:0] thr,
  output logic signed [SW-1:0] corr_q,
  output logic                 sync_q,
  output logic                 hit,
  output logic                 filled,
  output logic                 blanked
);

  localparam int CW = $clog2(LEN);

  logic [CW-1:0] fill_q;
  logic [CW-1:0] blank_q;
  logic          detect;

  assign hit     = pnacq_pkg::iabs(int'(sum_nx)) > int'(thr);
  assign filled  = (fill_q == CW'(LEN-1));
  assign blanked = (blank_q != '0);
  assign detect  = strobe & filled & ~blanked & hit;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      corr_q  <= '0;
      sync_q  <= 1'b0;
      fill_q  <= '0;
      blank_q <= '0;
    end else begin
      sync_q <= detect;
      if (strobe) begin
        corr_q <= sum_nx;
        if (!filled) fill_q <= fill_q + 1'b1;
        if (detect)       blank_q <= CW'(LEN-1);
        else if (blanked) blank_q <= blank_q - 1'b1;
      end
    end
  end

  // checker counters, independent of the blanking/fill registers
  logic [CW:0] a_seen;
  logic [CW:0] a_gap;
  logic        a_any;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      a_seen <= '0;
      a_gap  <= '0;
      a_any  <= 1'b0;
    end else begin
      if (strobe && a_seen != (CW+1)'(LEN)) a_seen <= a_seen + 1'b1;
      if (sync_q) begin
        a_any <= 1'b1;
        a_gap <= strobe ? (CW+1)'(1) : '0;
      end else if (strobe && a_gap != (CW+1)'(LEN)) begin
        a_gap <= a_gap + 1'b1;
      end
    end
  end

  p_sync_after_strobe_r5: assert property (@(posedge clk) disable iff (!rst_n)
    sync_q |-> $past(strobe));

  p_sync_single_r5: assert property (@(posedge clk) disable iff (!rst_n)
    sync_q |=> !sync_q);

  p_sync_exceeds_r5: assert property (@(posedge clk) disable iff (!rst_n)
    sync_q |-> pnacq_pkg::iabs(int'(corr_q)) > int'($past(thr)));

  p_corr_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && !$past(strobe)) |-> $stable(corr_q));

  p_corr_odd_r3: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && $past(strobe)) |-> (corr_q[0] == 1'b1));

  p_corr_range_r3: assert property (@(posedge clk) disable iff (!rst_n)
    pnacq_pkg::iabs(int'(corr_q)) <= LEN);

  p_no_sync_unfilled_r7: assert property (@(posedge clk) disable iff (!rst_n)
    sync_q |-> a_seen == (CW+1)'(LEN));

  p_blank_gap_r8: assert property (@(posedge clk) disable iff (!rst_n)
    sync_q |-> (!a_any || a_gap == (CW+1)'(LEN)));

endmodule

// File: rtl/pn_mf_acq.sv
module pn_mf_acq #(
  parameter int PN_DEG = 6,
  parameter int PN_TAP = 1,
  parameter int TW     = PN_DEG
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                chip_vld,
  input  logic                chip_in,
  input  logic [TW-1:0]       thr,
  output logic signed [TW:0]  corr_out,
  output logic                sync_out
);

  localparam int LEN = (1 << PN_DEG) - 1;
  localparam int SW  = TW + 1;
  localparam logic [pnacq_pkg::MAX_LEN-1:0] SEQ_ALL = pnacq_pkg::mseq_bits(PN_DEG, PN_TAP);
  localparam logic [LEN-1:0] COEF = SEQ_ALL[LEN-1:0];

  logic [LEN-1:0]        win_q;
  logic [LEN-1:0]        win_nx;
  logic [LEN-1:0]        coef_q;
  logic signed [SW-1:0]  sum_nx;
  logic                  ev_hit;
  logic                  ev_filled;
  logic                  ev_blanked;

  // coefficient register: one period of the local code
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) coef_q <= COEF;
    else        coef_q <= coef_q;
  end

  pnacq_window #(.LEN(LEN)) u_win (
    .clk    (clk),
    .rst_n  (rst_n),
    .shift  (chip_vld),
    .din    (chip_in),
    .win_q  (win_q),
    .win_nx (win_nx)
  );

  pnacq_corr #(.LEN(LEN), .SW(SW)) u_corr (
    .win  (win_nx),
    .coef (coef_q),
    .sum  (sum_nx)
  );

  pnacq_detect #(.LEN(LEN), .SW(SW), .TW(TW)) u_det (
    .clk     (clk),
    .rst_n   (rst_n),
    .strobe  (chip_vld),
    .sum_nx  (sum_nx),
    .thr     (thr),
    .corr_q  (corr_out),
    .sync_q  (sync_out),
    .hit     (ev_hit),
    .filled  (ev_filled),
    .blanked (ev_blanked)
  );

  p_reset_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(rst_n) |-> (corr_out == '0 && !sync_out));

  p_sync_needs_fill_r7: assert property (@(posedge clk) disable iff (!rst_n)
    sync_out |-> $past(ev_filled) && !$past(ev_blanked) && $past(ev_hit));

endmodule

// File: tb/pn_mf_acq_tb_top.sv
module pn_mf_acq_tb_top;

  localparam int CLK_PERIOD = 10;
  localparam int N = 63;
  localparam int WATCHDOG = 20000;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              chip_vld = 1'b0;
  logic              chip_in = 1'b0;
  logic [5:0]        thr = 6'd40;
  logic signed [6:0] corr_out;
  logic              sync_out;

  always #(CLK_PERIOD/2) clk = ~clk;

  pn_mf_acq dut_i (
    .clk(clk), .rst_n(rst_n), .chip_vld(chip_vld), .chip_in(chip_in),
    .thr(thr), .corr_out(corr_out), .sync_out(sync_out)
  );

  int total = 0;
  int bad = 0;
  int pn[N];
  int win[$];
  int nstrobe, last_det, exp_corr, idx;
  bit exp_sync;
  int ph_syncs, ph_model_syncs, ph_max, ph_min;
  int marks[$];

  task automatic check(input bit ok, input string req, input int act, input int expv);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, expv);
    end
  endtask

  task automatic model_reset();
    win.delete();
    for (int i = 0; i < N; i++) win.push_back(0);
    nstrobe = 0; last_det = -1000; exp_corr = 0; exp_sync = 0;
  endtask

  task automatic model_step(input bit v, input bit c, input int t);
    int s;
    exp_sync = 0;
    if (v) begin
      win.push_back(int'(c));
      void'(win.pop_front());
      nstrobe++;
      s = 0;
      for (int i = 0; i < N; i++) s += (win[i] == pn[i]) ? 1 : -1;
      exp_corr = s;
      if (nstrobe >= N && (s < 0 ? -s : s) > t && nstrobe - last_det >= N) begin
        exp_sync = 1;
        last_det = nstrobe;
      end
    end
  endtask

  task automatic tick(input bit v, input bit c);
    int t;
    chip_vld = v; chip_in = c;
    t = int'(thr);
    @(posedge clk);
    model_step(v, c, t);
    @(negedge clk);
    check(int'(corr_out) == exp_corr, v ? "R3 corr" : "R2 hold", int'(corr_out), exp_corr);
    check(sync_out == exp_sync, "R5 sync", int'(sync_out), int'(exp_sync));
    if (v) begin
      if (int'(corr_out) > ph_max) ph_max = int'(corr_out);
      if (int'(corr_out) < ph_min) ph_min = int'(corr_out);
    end
    if (sync_out) begin ph_syncs++; marks.push_back(nstrobe); end
    if (exp_sync) ph_model_syncs++;
  endtask

  task automatic phase_start();
    ph_syncs = 0; ph_model_syncs = 0; ph_max = -1000; ph_min = 1000;
    marks.delete();
  endtask

  task automatic send(input int count, input int data, input int flip, input int maxgap);
    for (int k = 0; k < count; k++) begin
      bit c;
      c = bit'(pn[idx] ^ data ^ ((idx == flip) ? 1 : 0));
      idx = (idx + 1) % N;
      tick(1'b1, c);
      repeat ((maxgap > 0) ? ($urandom % (maxgap + 1)) : 0) tick(1'b0, 1'b0);
    end
  endtask

  task automatic do_reset();
    chip_vld = 0; chip_in = 0;
    rst_n = 0;
    repeat (2) @(negedge clk);
    check(corr_out == 0, "R1 corr in reset", int'(corr_out), 0);
    check(sync_out == 0, "R1 sync in reset", int'(sync_out), 0);
    rst_n = 1;
    model_reset();
    @(negedge clk);
    check(corr_out == 0, "R1 corr after reset", int'(corr_out), 0);
    check(sync_out == 0, "R1 sync after reset", int'(sync_out), 0);
  endtask

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog actual=%0d expected=%0d", WATCHDOG, 0);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    for (int i = 0; i < 6; i++) pn[i] = 1;
    for (int n = 6; n < N; n++) pn[n] = pn[n-5] ^ pn[n-6];
    model_reset();
    @(negedge clk);
    do_reset();

    // A: clean stream, start mid-code, thr 40
    thr = 6'd40; idx = 17;
    phase_start();
    send(315, 0, -1, 2);
    check(ph_syncs == 4, "R4 peaks per period", ph_syncs, 4);
    check(ph_max == 63, "R4 aligned peak", ph_max, 63);

    // B: data bit 1, inverted peaks
    phase_start();
    send(189, 1, -1, 1);
    check(ph_min == -63, "R6 inverted peak", ph_min, -63);
    check(ph_syncs == ph_model_syncs && ph_syncs >= 2, "R6 inverted detect", ph_syncs, ph_model_syncs);

    // C: threshold at maximum, no detection
    thr = 6'd63;
    phase_start();
    send(126 + ((N - ((idx + 126) % N)) % N), 0, -1, 1);
    check(ph_syncs == 0, "R9 no sync at thr 63", ph_syncs, 0);
    check(ph_max == 63, "R9 peak still present", ph_max, 63);

    // D: one chip error per period, strict compare
    thr = 6'd61;
    phase_start();
    send(126, 0, 30, 0);
    check(ph_syncs == 0, "R5 strict compare", ph_syncs, 0);
    check(ph_max == 61, "R3 one error peak", ph_max, 61);
    thr = 6'd60;
    phase_start();
    send(126, 0, 30, 0);
    check(ph_syncs == 2, "R5 detect above thr", ph_syncs, 2);

    // R2: hold across idle cycles
    begin
      int held;
      tick(1'b1, 1'b1);
      held = int'(corr_out);
      repeat (5) tick(1'b0, 1'b1);
      check(int'(corr_out) == held, "R2 hold across gap", int'(corr_out), held);
    end

    // E: thr 0 on random chips, blanking sets spacing
    thr = 6'd0;
    phase_start();
    for (int k = 0; k < 300; k++) begin
      tick(1'b1, bit'($urandom % 2));
      if ((k % 3) == 0) tick(1'b0, 1'b0);
    end
    check(ph_syncs >= 4, "R8 sync count", ph_syncs, 4);
    for (int i = 1; i < marks.size(); i++)
      check(marks[i] - marks[i-1] == N, "R8 blank spacing", marks[i] - marks[i-1], N);

    // F: after reset, first sync only on the 63rd chip
    do_reset();
    thr = 6'd0;
    phase_start();
    for (int k = 0; k < 70; k++) tick(1'b1, bit'($urandom % 2));
    check(ph_syncs == 1, "R7 one sync after fill", ph_syncs, 1);
    check(marks.size() > 0 && marks[0] == N, "R7 first sync strobe",
          (marks.size() > 0) ? marks[0] : -1, N);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule